// File: doc/BRIEF.md
# DDR Read Burst Output Scheduler

This block is the device-side scheduler for the data-output path of a double-data-rate SDRAM. It takes one decoded command per clock: no-op, read (with bank and column), burst stop, or write. It turns reads into bursts of beats on two lanes per clock: the rising-edge lane and the falling-edge lane. Each lane has its own valid flag, and a shared output-enable tells the pad ring when to drive the bus.

Burst length and CAS latency are parameters. The latency may be a whole number of clocks or a whole number plus a half. With a half-clock latency the first beat lands on the falling lane. A later read cuts an earlier burst short: the old burst keeps driving until the new read's latency has run out, and from that point the new read's full burst takes over. A burst stop silences the output once its own latency has elapsed, so the bus is free before a write.

A small guard watches the spacing between read, burst stop and write. It raises a one-cycle protocol error when a write comes too early. The write is still accepted and ends any read beats not yet issued. Every beat carries a word that packs bank, column and beat index, so the beat order can be observed directly.

Top module: `ddr_rd_sched`

## Requirements
- R1: A synchronous active-high reset clears every pending beat. From the first clock after reset both valid flags, the output-enable and the protocol error are low, and both data lanes are zero.
- R2: With an integer latency CL, a read issued in cycle t puts beat 0 on the rising lane and beat 1 on the falling lane in cycle t+CL. The following beat pairs come in the following cycles, BURST_LEN/2 cycles in all.
- R3: With a latency of N+0.5 clocks, a read issued in cycle t puts beat 0 on the falling lane of cycle t+N. Each later beat takes the next half-clock slot, so beat 1 is on the rising lane of cycle t+N+1.
- R4: The data word of a valid beat is {bank, column, beat index}. The beat index is in bits [2:0], the column in bits [10:3] and the bank in bits [12:11].
- R5: The column of beat j keeps the upper bits of the read column. Its low log2(BURST_LEN) bits are (column + j) mod BURST_LEN, so the burst wraps inside its aligned block.
- R6: A read issued k cycles after an earlier read (1 ≤ k < BURST_LEN/2) drops the earlier burst's beats from index 2k onward. The new burst's full set of beats follows without a gap, from cycle t+k+CL.
- R7: A burst stop issued in cycle s suppresses every beat whose half-clock slot is at or after 2s+2·CL. With an integer latency, the outputs are idle from cycle s+CL.
- R8: The output-enable is high exactly in the cycles where at least one lane carries a valid beat. A lane without a valid beat drives zero.
- R9: A write issued fewer than ceil(CL) cycles after a burst stop raises the protocol error for exactly the next cycle. At exactly ceil(CL) cycles it raises nothing.
- R10: A write issued fewer than BURST_LEN/2+ceil(CL) cycles after the latest read, with no burst stop in between, raises the protocol error for the next cycle. At exactly that distance no error is raised.
- R11: A write is accepted even when it is flagged. Any beats of the current burst not yet issued are dropped, just as with a burst stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 2 | Command: 0 no-op, 1 read, 2 burst stop, 3 write |
| cmd_bank | input | 2 | Bank of a read |
| cmd_col | input | 8 | Starting column of a read |
| rise_data | output | 13 | Beat word on the rising-edge lane |
| fall_data | output | 13 | Beat word on the falling-edge lane |
| rise_valid | output | 1 | Rising lane carries a beat |
| fall_valid | output | 1 | Falling lane carries a beat |
| dq_oe | output | 1 | Output drivers enabled; low means high impedance |
| proto_err | output | 1 | One-cycle flag for a write that breaks read/stop/write spacing |

## Verification
The assertions assume that exactly one legal command code is presented on every clock. They also assume that the bank and column matter only while a read is on the bus. The beat-pairing and silence properties further assume that no reset arrives in the middle of a window that the checker is timing. The stimulus drives every command at the falling edge, keeps reset quiet except for one deliberate pulse, and leaves enough idle cycles between scenarios that each latency window closes before the next scenario starts.

// File: rtl/ddr_rd_pkg.sv
package ddr_rd_pkg;

    localparam int BANK_W = 2;
    localparam int COL_W  = 8;
    localparam int IDX_W  = 3;
    localparam int WORD_W = BANK_W + COL_W + IDX_W;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_READ  = 2'd1,
        CMD_BSTOP = 2'd2,
        CMD_WRITE = 2'd3
    } cmd_e;

    typedef struct packed {
        logic              vld;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        logic [IDX_W-1:0]  idx;
    } beat_t;

    typedef struct packed {
        beat_t r;
        beat_t f;
    } pair_t;

    function automatic int unsigned ceil_half(input int unsigned x2);
        return (x2 + 1) / 2;
    endfunction

    function automatic logic [COL_W-1:0] wrap_col(
        input logic [COL_W-1:0] base,
        input logic [IDX_W-1:0] idx,
        input int unsigned      blen
    );
        logic [COL_W-1:0] mask;
        mask = COL_W'(blen - 1);
        return (base & ~mask) | ((base + COL_W'(idx)) & mask);
    endfunction

    function automatic beat_t make_beat(
        input logic [BANK_W-1:0] bank,
        input logic [COL_W-1:0]  base,
        input logic [IDX_W-1:0]  idx,
        input int unsigned       blen
    );
        beat_t b;
        b.vld  = 1'b1;
        b.bank = bank;
        b.col  = wrap_col(base, idx, blen);
        b.idx  = idx;
        return b;
    endfunction

    function automatic logic [WORD_W-1:0] beat_word(input beat_t b);
        return b.vld ? {b.bank, b.col, b.idx} : '0;
    endfunction

endpackage

// File: rtl/rd_beat_gen.sv
module rd_beat_gen
    import ddr_rd_pkg::*;
#(
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              cmd,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    output pair_t             issue
);
    localparam int CNT_W = $clog2(BURST_LEN) + 1;

    logic              act_q, act_d;
    logic [CNT_W-1:0]  nxt_q, nxt_d;
    logic [BANK_W-1:0] bank_q, bank_d;
    logic [COL_W-1:0]  col_q, col_d;

    always_comb begin
        issue  = '0;
        act_d  = act_q;
        nxt_d  = nxt_q;
        bank_d = bank_q;
        col_d  = col_q;
        case (cmd)
            CMD_READ: begin
                issue.r = make_beat(cmd_bank, cmd_col, IDX_W'(0), BURST_LEN);
                issue.f = make_beat(cmd_bank, cmd_col, IDX_W'(1), BURST_LEN);
                act_d   = (BURST_LEN > 2);
                nxt_d   = CNT_W'(2);
                bank_d  = cmd_bank;
                col_d   = cmd_col;
            end
            CMD_BSTOP, CMD_WRITE: begin
                act_d = 1'b0;
            end
            default: begin
                if (act_q) begin
                    issue.r = make_beat(bank_q, col_q, IDX_W'(nxt_q), BURST_LEN);
                    issue.f = make_beat(bank_q, col_q, IDX_W'(nxt_q + CNT_W'(1)), BURST_LEN);
                    nxt_d   = nxt_q + CNT_W'(2);
                    act_d   = (nxt_q + CNT_W'(2)) < CNT_W'(BURST_LEN);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            nxt_q  <= '0;
            bank_q <= '0;
            col_q  <= '0;
        end else begin
            act_q  <= act_d;
            nxt_q  <= nxt_d;
            bank_q <= bank_d;
            col_q  <= col_d;
        end
    end

endmodule

// File: rtl/rd_lat_pipe.sv
module rd_lat_pipe
    import ddr_rd_pkg::*;
#(
    parameter int CL_X2 = 6
) (
    input  logic  clk,
    input  logic  rst,
    input  pair_t issue,
    output beat_t out_r,
    output beat_t out_f
);
    localparam int HALF = CL_X2 / 2;
    localparam bit ODD  = (CL_X2 % 2) != 0;

    pair_t st [HALF];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < HALF; i++) st[i] <= '0;
        end else begin
            st[0] <= issue;
            for (int i = 1; i < HALF; i++) st[i] <= st[i-1];
        end
    end

    generate
        if (ODD) begin : g_half
            beat_t held_f;
            always_ff @(posedge clk) begin
                if (rst) held_f <= '0;
                else     held_f <= st[HALF-1].f;
            end
            assign out_r = held_f;
            assign out_f = st[HALF-1].r;
        end else begin : g_whole
            assign out_r = st[HALF-1].r;
            assign out_f = st[HALF-1].f;
        end
    endgenerate

endmodule

// File: rtl/rd_wr_guard.sv
module rd_wr_guard
    import ddr_rd_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int CL_X2     = 6
) (
    input  logic clk,
    input  logic rst,
    input  cmd_e cmd,
    output logic err
);
    localparam int CLC  = ceil_half(CL_X2);
    localparam int LIVE = BURST_LEN / 2 + CLC;
    localparam int SW   = $clog2(CLC + 1);
    localparam int RW   = $clog2(LIVE + 1);

    logic [SW-1:0] stop_age;
    logic [RW-1:0] read_age;
    logic          stop_seen;
    logic          early_stop, open_read;

    assign early_stop = stop_age < SW'(CLC - 1);
    assign open_read  = !stop_seen && (read_age < RW'(LIVE - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            stop_age  <= SW'(CLC);
            read_age  <= RW'(LIVE);
            stop_seen <= 1'b0;
            err       <= 1'b0;
        end else begin
            err <= (cmd == CMD_WRITE) && (early_stop || open_read);
            if (cmd == CMD_READ) begin
                read_age  <= '0;
                stop_seen <= 1'b0;
            end else if (read_age < RW'(LIVE)) begin
                read_age <= read_age + RW'(1);
            end
            if (cmd == CMD_BSTOP) begin
                stop_age  <= '0;
                stop_seen <= 1'b1;
            end else if (stop_age < SW'(CLC)) begin
                stop_age <= stop_age + SW'(1);
            end
        end
    end

endmodule

// File: rtl/ddr_rd_sched.sv
module ddr_rd_sched
    import ddr_rd_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int CL_X2     = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cmd,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    output logic [WORD_W-1:0] rise_data,
    output logic [WORD_W-1:0] fall_data,
    output logic              rise_valid,
    output logic              fall_valid,
    output logic              dq_oe,
    output logic              proto_err
);
    cmd_e  cmd_t;
    pair_t issue;
    beat_t beat_r, beat_f;

    assign cmd_t = cmd_e'(cmd);

    rd_beat_gen #(.BURST_LEN(BURST_LEN)) u_gen (
        .clk(clk), .rst(rst), .cmd(cmd_t),
        .cmd_bank(cmd_bank), .cmd_col(cmd_col), .issue(issue)
    );

    rd_lat_pipe #(.CL_X2(CL_X2)) u_pipe (
        .clk(clk), .rst(rst), .issue(issue),
        .out_r(beat_r), .out_f(beat_f)
    );

    rd_wr_guard #(.BURST_LEN(BURST_LEN), .CL_X2(CL_X2)) u_guard (
        .clk(clk), .rst(rst), .cmd(cmd_t), .err(proto_err)
    );

    assign rise_data  = beat_word(beat_r);
    assign fall_data  = beat_word(beat_f);
    assign rise_valid = beat_r.vld;
    assign fall_valid = beat_f.vld;
    assign dq_oe      = beat_r.vld | beat_f.vld;

endmodule

// File: rtl/rd_sched_chk.sv
module rd_sched_chk
    import ddr_rd_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int CL_X2     = 6
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        cmd,
    input logic [WORD_W-1:0] rise_data,
    input logic [WORD_W-1:0] fall_data,
    input logic              rise_valid,
    input logic              fall_valid,
    input logic              dq_oe,
    input logic              proto_err
);
    localparam int CLC  = ceil_half(CL_X2);
    localparam int LIVE = BURST_LEN / 2 + CLC;
    localparam int AW   = $clog2(LIVE + 2);

    logic [AW-1:0] since_read, since_stop;
    logic          stop_after_read;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_read      <= AW'(LIVE + 1);
            since_stop      <= AW'(LIVE + 1);
            stop_after_read <= 1'b0;
        end else begin
            if (cmd == CMD_READ) since_read <= '0;
            else if (since_read < AW'(LIVE + 1)) since_read <= since_read + AW'(1);
            if (cmd == CMD_BSTOP) since_stop <= '0;
            else if (since_stop < AW'(LIVE + 1)) since_stop <= since_stop + AW'(1);
            if (cmd == CMD_READ) stop_after_read <= 1'b0;
            else if (cmd == CMD_BSTOP) stop_after_read <= 1'b1;
        end
    end

    // R1: reset leaves the bus quiet
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!dq_oe && !proto_err && rise_data == '0 && fall_data == '0));

    // R9: the error flag only follows a write
    p_err_after_write_r9: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> ($past(cmd) == CMD_WRITE));

    // R8: the bus is driven only inside the window of the latest read
    p_oe_window_r8: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (since_read < AW'(LIVE)));

    // R7: after a stop's latency the bus stays quiet
    p_stop_silence_r7: assert property (@(posedge clk) disable iff (rst)
        (stop_after_read && since_stop >= AW'(CLC - 1) && since_stop <= AW'(LIVE)) |-> !dq_oe);

    generate
        if ((CL_X2 % 2) == 0) begin : g_even
            // R5: a whole-clock pair is two consecutive beats of one burst
            p_pair_order_r5: assert property (@(posedge clk) disable iff (rst)
                (rise_valid && fall_valid) |->
                    (fall_data[IDX_W-1:0] == rise_data[IDX_W-1:0] + IDX_W'(1)
                     && fall_data[WORD_W-1:WORD_W-BANK_W] == rise_data[WORD_W-1:WORD_W-BANK_W]));
        end else begin : g_odd
            // R3: with a half-clock latency even beats ride the falling lane
            p_fall_even_r3: assert property (@(posedge clk) disable iff (rst)
                fall_valid |-> (fall_data[0] == 1'b0));
        end
    endgenerate

endmodule

bind ddr_rd_sched rd_sched_chk #(.BURST_LEN(BURST_LEN), .CL_X2(CL_X2)) u_chk (
    .clk(clk), .rst(rst), .cmd(cmd),
    .rise_data(rise_data), .fall_data(fall_data),
    .rise_valid(rise_valid), .fall_valid(fall_valid),
    .dq_oe(dq_oe), .proto_err(proto_err)
);

// File: tb/tb_ddr_rd_sched.sv
module tb_ddr_rd_sched;
    import ddr_rd_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int BL = 4;
    localparam int NLOG = 1024;

    // vector: bank, column, expected words of beats 0..3 (R4, R5)
    localparam int NVEC = 4;
    localparam logic [61:0] VEC [NVEC] = '{
        {2'd0, 8'h00, 13'h0000, 13'h0009, 13'h0012, 13'h001B},
        {2'd1, 8'h05, 13'h0828, 13'h0831, 13'h083A, 13'h0823},
        {2'd2, 8'hFE, 13'h17F0, 13'h17F9, 13'h17E2, 13'h17EB},
        {2'd3, 8'h83, 13'h1C18, 13'h1C01, 13'h1C0A, 13'h1C13}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] cmd = 2'd0;
    logic [1:0] cmd_bank = '0;
    logic [7:0] cmd_col = '0;

    logic [12:0] rd [2], fd [2];
    logic rv [2], fv [2], oe [2], er [2];

    logic [12:0] l_rd [2][NLOG];
    logic [12:0] l_fd [2][NLOG];
    logic l_rv [2][NLOG];
    logic l_fv [2][NLOG];
    logic l_oe [2][NLOG];
    logic l_er [2][NLOG];

    int ncyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddr_rd_sched #(.BURST_LEN(BL), .CL_X2(6)) dut (
        .clk(clk), .rst(rst), .cmd(cmd), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
        .rise_data(rd[0]), .fall_data(fd[0]), .rise_valid(rv[0]), .fall_valid(fv[0]),
        .dq_oe(oe[0]), .proto_err(er[0])
    );

    ddr_rd_sched #(.BURST_LEN(BL), .CL_X2(5)) dut_h (
        .clk(clk), .rst(rst), .cmd(cmd), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
        .rise_data(rd[1]), .fall_data(fd[1]), .rise_valid(rv[1]), .fall_valid(fv[1]),
        .dq_oe(oe[1]), .proto_err(er[1])
    );

    function automatic logic [12:0] ew(input logic [1:0] b, input logic [7:0] c, input int j);
        logic [7:0] col;
        col = (c & 8'hFC) | ((c + 8'(j)) & 8'h03);
        return {b, col, 3'(j)};
    endfunction

    task automatic step(input cmd_e c, input logic [1:0] b, input logic [7:0] col,
                        input logic r, output int idx);
        @(negedge clk);
        for (int d = 0; d < 2; d++) begin
            l_rd[d][ncyc] = rd[d];
            l_fd[d][ncyc] = fd[d];
            l_rv[d][ncyc] = rv[d];
            l_fv[d][ncyc] = fv[d];
            l_oe[d][ncyc] = oe[d];
            l_er[d][ncyc] = er[d];
        end
        cmd = c;
        cmd_bank = b;
        cmd_col = col;
        rst = r;
        idx = ncyc;
        ncyc++;
    endtask

    task automatic idle(input int n);
        int k;
        for (int i = 0; i < n; i++) step(CMD_NOP, 2'd0, 8'd0, 1'b0, k);
    endtask

    task automatic chk_cyc(input string rq, input int d, input int n,
                           input logic ervl, input logic [12:0] erw,
                           input logic efvl, input logic [12:0] efw);
        logic [12:0] xr, xf;
        logic xo;
        xr = ervl ? erw : 13'h0;
        xf = efvl ? efw : 13'h0;
        xo = ervl | efvl;
        checks++;
        if (l_rv[d][n] !== ervl || l_fv[d][n] !== efvl || l_rd[d][n] !== xr ||
            l_fd[d][n] !== xf || l_oe[d][n] !== xo) begin
            errors++;
            $display("FAIL %s dut%0d cyc %0d: actual rv=%b rw=%h fv=%b fw=%h oe=%b expected rv=%b rw=%h fv=%b fw=%h oe=%b",
                     rq, d, n, l_rv[d][n], l_rd[d][n], l_fv[d][n], l_fd[d][n], l_oe[d][n],
                     ervl, xr, efvl, xf, xo);
        end
    endtask

    task automatic chk_err(input string rq, input int d, input int n, input logic e);
        checks++;
        if (l_er[d][n] !== e) begin
            errors++;
            $display("FAIL %s dut%0d cyc %0d: actual err=%b expected err=%b", rq, d, n, l_er[d][n], e);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int t, k;
        // reset: R1
        step(CMD_NOP, 2'd0, 8'd0, 1'b1, k);
        step(CMD_NOP, 2'd0, 8'd0, 1'b1, k);
        step(CMD_NOP, 2'd0, 8'd0, 1'b1, k);
        step(CMD_NOP, 2'd0, 8'd0, 1'b0, k);
        for (int d = 0; d < 2; d++) begin
            chk_cyc("R1", d, 1, 1'b0, 0, 1'b0, 0);
            chk_cyc("R1", d, 2, 1'b0, 0, 1'b0, 0);
            chk_err("R1", d, 2, 1'b0);
        end

        // vector table: single reads, R2 R3 R4 R5 R8
        for (int v = 0; v < NVEC; v++) begin
            logic [1:0] vb;
            logic [7:0] vc;
            logic [12:0] w0, w1, w2, w3;
            {vb, vc, w0, w1, w2, w3} = VEC[v];
            step(CMD_READ, vb, vc, 1'b0, t);
            idle(5);
            chk_cyc("R2", 0, t + 3, 1'b1, w0, 1'b1, w1);
            chk_cyc("R2", 0, t + 4, 1'b1, w2, 1'b1, w3);
            chk_cyc("R8", 0, t + 5, 1'b0, 0, 1'b0, 0);
            chk_cyc("R3", 1, t + 2, 1'b0, 0, 1'b1, w0);
            chk_cyc("R3", 1, t + 3, 1'b1, w1, 1'b1, w2);
            chk_cyc("R8", 1, t + 4, 1'b1, w3, 1'b0, 0);
            chk_cyc("R8", 1, t + 5, 1'b0, 0, 1'b0, 0);
        end

        // read interrupted by read one clock later: R6
        step(CMD_READ, 2'd0, 8'h00, 1'b0, t);
        step(CMD_READ, 2'd1, 8'h05, 1'b0, k);
        idle(6);
        chk_cyc("R6", 0, t + 3, 1'b1, ew(0, 8'h00, 0), 1'b1, ew(0, 8'h00, 1));
        chk_cyc("R6", 0, t + 4, 1'b1, ew(1, 8'h05, 0), 1'b1, ew(1, 8'h05, 1));
        chk_cyc("R6", 0, t + 5, 1'b1, ew(1, 8'h05, 2), 1'b1, ew(1, 8'h05, 3));
        chk_cyc("R6", 0, t + 6, 1'b0, 0, 1'b0, 0);
        chk_cyc("R6", 1, t + 2, 1'b0, 0, 1'b1, ew(0, 8'h00, 0));
        chk_cyc("R6", 1, t + 3, 1'b1, ew(0, 8'h00, 1), 1'b1, ew(1, 8'h05, 0));
        chk_cyc("R6", 1, t + 4, 1'b1, ew(1, 8'h05, 1), 1'b1, ew(1, 8'h05, 2));
        chk_cyc("R6", 1, t + 5, 1'b1, ew(1, 8'h05, 3), 1'b0, 0);

        // burst stop then write at exactly ceil(CL): R7, R9 boundary
        step(CMD_READ, 2'd2, 8'h10, 1'b0, t);
        step(CMD_BSTOP, 2'd0, 8'd0, 1'b0, k);
        idle(2);
        step(CMD_WRITE, 2'd0, 8'd0, 1'b0, k);
        idle(5);
        chk_cyc("R7", 0, t + 3, 1'b1, ew(2, 8'h10, 0), 1'b1, ew(2, 8'h10, 1));
        chk_cyc("R7", 0, t + 4, 1'b0, 0, 1'b0, 0);
        chk_cyc("R7", 1, t + 3, 1'b1, ew(2, 8'h10, 1), 1'b0, 0);
        chk_cyc("R7", 1, t + 4, 1'b0, 0, 1'b0, 0);
        chk_err("R9", 0, t + 5, 1'b0);
        chk_err("R9", 1, t + 5, 1'b0);

        // write too soon after burst stop: R9
        step(CMD_READ, 2'd0, 8'h20, 1'b0, t);
        step(CMD_BSTOP, 2'd0, 8'd0, 1'b0, k);
        idle(1);
        step(CMD_WRITE, 2'd0, 8'd0, 1'b0, k);
        idle(6);
        chk_err("R9", 0, t + 4, 1'b1);
        chk_err("R9", 0, t + 5, 1'b0);
        chk_err("R9", 1, t + 4, 1'b1);

        // write right after read with no stop: R10, R11
        step(CMD_READ, 2'd1, 8'h05, 1'b0, t);
        step(CMD_WRITE, 2'd0, 8'd0, 1'b0, k);
        idle(7);
        chk_err("R10", 0, t + 2, 1'b1);
        chk_err("R10", 0, t + 3, 1'b0);
        chk_cyc("R11", 0, t + 3, 1'b1, ew(1, 8'h05, 0), 1'b1, ew(1, 8'h05, 1));
        chk_cyc("R11", 0, t + 4, 1'b0, 0, 1'b0, 0);
        chk_cyc("R11", 1, t + 2, 1'b0, 0, 1'b1, ew(1, 8'h05, 0));
        chk_cyc("R11", 1, t + 3, 1'b1, ew(1, 8'h05, 1), 1'b0, 0);
        chk_cyc("R11", 1, t + 4, 1'b0, 0, 1'b0, 0);

        // write one clock before the read window closes: R10
        step(CMD_READ, 2'd3, 8'h40, 1'b0, t);
        idle(3);
        step(CMD_WRITE, 2'd0, 8'd0, 1'b0, k);
        idle(6);
        chk_err("R10", 0, t + 5, 1'b1);
        chk_err("R10", 1, t + 5, 1'b1);

        // write exactly at the window edge: R10 boundary
        step(CMD_READ, 2'd3, 8'h40, 1'b0, t);
        idle(4);
        step(CMD_WRITE, 2'd0, 8'd0, 1'b0, k);
        idle(4);
        chk_err("R10", 0, t + 6, 1'b0);
        chk_cyc("R2", 0, t + 4, 1'b1, ew(3, 8'h40, 2), 1'b1, ew(3, 8'h40, 3));

        // reset in mid-burst: R1
        step(CMD_READ, 2'd2, 8'h33, 1'b0, t);
        step(CMD_NOP, 2'd0, 8'd0, 1'b1, k);
        idle(6);
        for (int d = 0; d < 2; d++) begin
            for (int n = t + 2; n <= t + 5; n++) chk_cyc("R1", d, n, 1'b0, 0, 1'b0, 0);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule